// File: doc/BRIEF.md
# Serial Slot-Assignment Control Port

This block is the configuration side of a time-slot assigner for eight frame-sync outputs: four transmit and four receive. A host sends one 8-bit control word over a three-wire serial link made of a control clock, an active-low select and a data line. Alongside the word it drives a set of channel-select lines. When the select is released, the block decodes the word's two action bits against the mode input. It then updates the stored slot number and enable flag of the outputs the word addresses.

Two addressing modes exist. Paired mode addresses one of four channels and picks transmit, receive or both from the action bits. Direct mode uses three select lines to name any one of the eight outputs. The stored slot/enable pairs feed a separate frame-sync generator, which is not part of this block.

Top module: `slot_cfg_port`

## Requirements
- R1: The word is shifted in on rising control-clock edges with the first bit as the most significant bit. Bit 7 is action bit A1, bit 6 is action bit A0, and bits 5..0 are the slot number (0..63).
- R2: A data bit is taken only on an edge where `cs_n` is low. Toggling `sdi` while `cs_n` is high changes no output.
- R3: In paired mode (`mode_pair`=1), `sel[1:0]` names channel c. A1A0=00 writes the slot into transmit output c and receive output c and enables both. 01 does this for transmit c only, and 10 for receive c only. 11 clears both enables and leaves both slot numbers unchanged.
- R4: In direct mode (`mode_pair`=0), `sel` value 0..3 names transmit output 0..3, and 4..7 names receive output 0..3.
- R5: In direct mode, A1A0 of 00, 01 or 10 writes the slot into the named output and enables it. 11 clears its enable and keeps its slot number.
- R6: `mode_pair`=1 selects paired mode and `mode_pair`=0 selects direct mode. In paired mode `sel[2]` has no effect.
- R7: `sel` is captured on the edge that takes the first data bit. Later changes to `sel` within the same word have no effect.
- R8: The word is applied only when exactly 8 bits were taken before `cs_n` rose. A shorter or longer burst changes no output.
- R9: While `rst_n` is low at a clock edge, all eight enables and all slot numbers are cleared to 0.
- R10: Outputs that a word does not address keep their slot number and enable.
- R11: The update is visible right after the first control-clock edge that samples `cs_n` high following the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low word framing select |
| sdi | input | 1 | Serial control data, first bit = MSB |
| sel | input | 3 | Channel/output select, captured with the first bit |
| mode_pair | input | 1 | 1 = paired mode, 0 = direct mode |
| out_en | output | 8 | Enable per output; bits 0..3 transmit 0..3, bits 4..7 receive 0..3 |
| out_slot | output | 8x6 | Slot number per output, same index order as `out_en` |

## Verification
The assertions assume that `cs_n`, `sdi` and `sel` change only away from the rising control-clock edge. They also assume that `mode_pair` stays steady over a word, because it is sampled only at the moment of release. The bench drives every input on the falling edge and sets the mode before the select goes low, so it keeps within these assumptions. The properties also take it that the outputs can change only on a release edge or under reset. The bench therefore issues reset only between words, never inside a burst.

// File: rtl/scp_pkg.sv
// Shared definitions for the serial slot-assignment control port.
// Assumes the action field is the two most significant bits of the word.
package scp_pkg;
    typedef enum logic [1:0] {
        ACT_BOTH = 2'b00,
        ACT_TX   = 2'b01,
        ACT_RX   = 2'b10,
        ACT_OFF  = 2'b11
    } act_e;
endpackage

// File: rtl/scp_shift.sv
// Serial word receiver: shifts data MSB first while cs_n is low, counts bits
// (saturating one past a full word), captures the select with the first bit,
// and flags a completed word on the edge that sees cs_n released.
// Assumes inputs are stable around the rising clock edge.
module scp_shift #(
    parameter int WORD_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [WORD_W-1:0] word_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             low_q;

    // Shift data, count bits, capture select on the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_o <= '0;
            sel_o  <= '0;
            low_q  <= 1'b0;
        end else begin
            low_q <= !cs_n;
            if (cs_n) begin
                cnt_q <= '0;
            end else begin
                word_o <= {word_o[WORD_W-2:0], sdi};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) sel_o <= sel_in;
            end
        end
    end

    // A word is complete when the select rises after exactly WORD_W bits.
    always_comb done_o = cs_n && low_q && (cnt_q == CNT_FULL);
endmodule

// File: rtl/scp_decode.sv
// Action decoder: turns mode, captured select and action bits into a mask of
// outputs to write and the enable value to write. Purely combinational.
// Assumes N_CH is a power of two so the direct-mode select spans all outputs.
module scp_decode
    import scp_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                      mode_pair,
    input  logic [$clog2(2*N_CH)-1:0] sel,
    input  act_e                      act,
    output logic [2*N_CH-1:0]         mask,
    output logic                      en_val
);
    localparam int CH_W = $clog2(N_CH);

    logic [CH_W-1:0] ch;

    // Build the write mask according to the addressing mode.
    always_comb begin
        mask   = '0;
        en_val = (act != ACT_OFF);
        ch     = sel[CH_W-1:0];
        if (mode_pair) begin
            unique case (act)
                ACT_TX:  mask[int'(ch)] = 1'b1;
                ACT_RX:  mask[N_CH + int'(ch)] = 1'b1;
                default: begin
                    mask[int'(ch)]        = 1'b1;
                    mask[N_CH + int'(ch)] = 1'b1;
                end
            endcase
        end else begin
            mask[int'(sel)] = 1'b1;
        end
    end
endmodule

// File: rtl/scp_store.sv
// Assignment store: one slot register and enable flag per output, written
// under a mask. Disabling keeps the slot number. Synchronous active-low reset.
module scp_store #(
    parameter int NOUT   = 8,
    parameter int SLOT_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [NOUT-1:0]             mask,
    input  logic                        en_val,
    input  logic [SLOT_W-1:0]           slot_val,
    output logic [NOUT-1:0]             out_en,
    output logic [NOUT-1:0][SLOT_W-1:0] out_slot
);
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        // Hold or update one output's assignment.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_en[i]   <= 1'b0;
                out_slot[i] <= '0;
            end else if (wr && mask[i]) begin
                out_en[i] <= en_val;
                if (en_val) out_slot[i] <= slot_val;
            end
        end
    end
endmodule

// File: rtl/slot_cfg_port.sv
// Serial slot-assignment control port: receives framed 8-bit control words
// and keeps a slot number and enable per frame-sync output (transmit 0..N_CH-1
// then receive 0..N_CH-1). Assumes mode_pair is steady across a word.
module slot_cfg_port
    import scp_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int SLOT_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          sdi,
    input  logic [$clog2(2*N_CH)-1:0]     sel,
    input  logic                          mode_pair,
    output logic [2*N_CH-1:0]             out_en,
    output logic [2*N_CH-1:0][SLOT_W-1:0] out_slot
);
    localparam int NOUT   = 2 * N_CH;
    localparam int SEL_W  = $clog2(NOUT);
    localparam int WORD_W = SLOT_W + 2;

    logic [WORD_W-1:0] word;
    logic [SEL_W-1:0]  sel_cap;
    logic              done;
    logic [NOUT-1:0]   mask;
    logic              en_val;
    act_e              act;

    scp_shift #(.WORD_W(WORD_W), .SEL_W(SEL_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sel_in(sel),
        .word_o(word), .sel_o(sel_cap), .done_o(done)
    );

    // Action field sits in the two most significant word bits.
    always_comb act = act_e'(word[WORD_W-1 -: 2]);

    scp_decode #(.N_CH(N_CH)) i_decode (
        .mode_pair(mode_pair), .sel(sel_cap), .act(act),
        .mask(mask), .en_val(en_val)
    );

    scp_store #(.NOUT(NOUT), .SLOT_W(SLOT_W)) i_store (
        .clk(clk), .rst_n(rst_n), .wr(done), .mask(mask), .en_val(en_val),
        .slot_val(word[SLOT_W-1:0]), .out_en(out_en), .out_slot(out_slot)
    );
endmodule

// File: rtl/scp_checker.sv
// Property checker for slot_cfg_port, attached by bind below.
// Assumes inputs change away from the rising clock edge.
module scp_checker #(
    parameter int NOUT   = 8,
    parameter int SLOT_W = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cs_n,
    input logic                        done,
    input logic [1:0]                  act,
    input logic [NOUT-1:0]             out_en,
    input logic [NOUT-1:0][SLOT_W-1:0] out_slot
);
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (out_en == '0) && (out_slot == '0));

    assert_hold_unaddressed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(out_en) && $stable(out_slot));

    assert_commit_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    assert_disable_keeps_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act == 2'b11) |=> $stable(out_slot) && ((out_en & ~$past(out_en)) == '0));

    assert_assign_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act != 2'b11) |=> (out_en != '0));
endmodule

bind slot_cfg_port scp_checker #(.NOUT(2*N_CH), .SLOT_W(SLOT_W)) i_scp_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .done(done), .act(act),
    .out_en(out_en), .out_slot(out_slot)
);

// File: tb/test_slot_cfg_port.sv
module test_slot_cfg_port;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sdi = 1'b0;
    logic [2:0]       sel = '0;
    logic             mode_pair = 1'b1;
    logic [7:0]       out_en;
    logic [7:0][5:0]  out_slot;

    logic [7:0]       en_m;
    logic [7:0][5:0]  slot_m;
    int               n_chk = 0;
    int               n_bad = 0;
    bit               timed_out = 1'b0;

    always #10 clk = !clk;

    slot_cfg_port i_slot_cfg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sel(sel),
        .mode_pair(mode_pair), .out_en(out_en), .out_slot(out_slot)
    );

    // {mode, sel[2:0], word[7:0], nbits[3:0], mask[7:0], en}
    localparam int NV = 15;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'b00_000101, 4'd8, 8'h11, 1'b1},  // R3 both
        {1'b1, 3'd1, 8'b01_101010, 4'd8, 8'h02, 1'b1},  // R3 tx only
        {1'b1, 3'd2, 8'b10_111111, 4'd8, 8'h40, 1'b1},  // R3 rx only, slot 63
        {1'b1, 3'd3, 8'b00_000000, 4'd8, 8'h88, 1'b1},  // R1 slot 0
        {1'b1, 3'd1, 8'b10_000111, 4'd8, 8'h20, 1'b1},  // R10 others kept
        {1'b1, 3'd0, 8'b11_010101, 4'd8, 8'h11, 1'b0},  // R3 disable
        {1'b1, 3'd6, 8'b01_001100, 4'd8, 8'h04, 1'b1},  // R6 sel[2] ignored
        {1'b0, 3'd5, 8'b00_100000, 4'd8, 8'h20, 1'b1},  // R4 rx1
        {1'b0, 3'd7, 8'b01_011110, 4'd8, 8'h80, 1'b1},  // R5 xr=01
        {1'b0, 3'd0, 8'b10_011111, 4'd8, 8'h01, 1'b1},  // R5 xr=10
        {1'b0, 3'd6, 8'b11_000001, 4'd8, 8'h40, 1'b0},  // R5 disable
        {1'b0, 3'd3, 8'b11_111000, 4'd8, 8'h08, 1'b0},  // R4 tx3 disable
        {1'b1, 3'd2, 8'b00_100001, 4'd8, 8'h44, 1'b1},  // R11 timing
        {1'b1, 3'd0, 8'b00_001001, 4'd7, 8'h00, 1'b0},  // R8 short
        {1'b1, 3'd0, 8'b00_001001, 4'd9, 8'h00, 1'b0}   // R8 long
    };

    task automatic check(input string tag);
        n_chk++;
        if (out_en !== en_m || out_slot !== slot_m) begin
            n_bad++;
            $display("FAIL %s: en=%h slot=%h expected en=%h slot=%h",
                     tag, out_en, out_slot, en_m, slot_m);
        end
    endtask

    // Send nbits of word MSB first; sel changes to sel_late after the first bit.
    task automatic send(input logic md, input logic [2:0] s, input logic [7:0] w,
                        input int nbits, input logic [2:0] sel_late);
        @(negedge clk);
        mode_pair = md;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            cs_n = 1'b0;
            sel  = (b == 0) ? s : sel_late;
            sdi  = (b < 8) ? w[7-b] : 1'b0;
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);   // release edge has passed: update visible (R11)
    endtask

    function automatic void model(input logic [7:0] m, input logic e, input logic [5:0] s);
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                en_m[i] = e;
                if (e) slot_m[i] = s;
            end
        end
    endfunction

    initial begin
        #1_000_000;
        timed_out = 1'b1;
    end

    initial begin
        en_m = '0;
        slot_m = '0;
        repeat (3) @(negedge clk);
        check("R9 reset state");
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [24:0] e;
            e = VEC[v];
            send(e[24], e[23:21], e[20:13], int'(e[12:9]), e[23:21]);
            model(e[8:1], e[0], e[18:13]);
            check($sformatf("vector %0d (R1 R3 R4 R5 R6 R8 R10 R11)", v));
            if (timed_out) break;
        end

        // R7: select changed after the first bit is ignored.
        send(1'b0, 3'd2, 8'b00_010001, 8, 3'd5);
        model(8'h04, 1'b1, 6'd17);
        check("R7 late select ignored");

        // R2: data toggled with select high changes nothing.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            sdi = k[0];
            sel = k[2:0];
        end
        @(negedge clk);
        check("R2 idle data ignored");

        // R8: a word split by a select pulse is discarded in both halves.
        send(1'b1, 3'd1, 8'b00_110011, 4, 3'd1);
        send(1'b1, 3'd1, 8'b00_110011, 4, 3'd1);
        check("R8 split burst discarded");

        // R9: reset mid-operation clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        en_m = '0;
        slot_m = '0;
        check("R9 reset clears");

        // R3 after reset: assign both on channel 3, slot 62.
        send(1'b1, 3'd3, 8'b00_111110, 8, 3'd3);
        model(8'h88, 1'b1, 6'd62);
        check("R3 assign after reset");

        if (timed_out) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule